// File: doc/BRIEF.md
# Random Number Generator Control Front End

This block is the register-mapped control and status shell that sits in front of a random number source. Software issues 32-bit register writes to start a self-test or a seeding run, picks which interrupt sources may reach the interrupt line, and clears pending events. It reads back completion flags, an error word and the fill level of an output queue. Random words are taken from the queue one per read.

Self-test and seeding are modelled as fixed-length operations of `OP_CYCLES` clocks. A test input can force the next operation to fail, so the error path can be exercised. The queue holds `DEPTH` words. It is filled from a 32-bit Galois LFSR, and only after a seeding run has succeeded.

The two clear commands follow different rules. Clear-interrupt does nothing while any error bit is latched. Clear-error empties the error word and drops every pending interrupt.

Top module: `rng_ctrl_regs`

## Requirements
- R1: After reset, control reads 0x60 (both interrupt sources masked), status reads 0, error reads 0 and `irq_o` is low. Register offsets are: command 0x04, control 0x08, status 0x0C, error 0x10, queue 0x14.
- R2: Command bits act as one-cycle pulses and the command register reads back 0. Control keeps only bit 5 (done mask) and bit 6 (error mask); every other bit reads 0.
- R3: Command bit 0 starts a self-test and bit 1 starts a seeding run; bit 0 wins if both are set. The matching done flag clears when the operation starts. The flag is status bit 4 for self-test and status bit 5 for seeding. It reads 1 starting exactly `OP_CYCLES` clocks after the clock edge that accepted the start.
- R4: A start command written while an operation is running is ignored. It changes no done flag and starts no later run.
- R5: `irq_o` is high when a done event is pending and bit 5 of control is 0, or when an error event is pending and bit 6 of control is 0. Changing a mask takes effect combinationally.
- R6: When `force_fail_i` is sampled high with an accepted start, that operation fails. A failed self-test sets error bit 2 and a failed seeding run sets error bit 3. The done flag is still set, and an error event becomes pending. Status bit 16 reads 1 whenever the error word is non-zero.
- R7: Command bit 4 (clear interrupt) drops the pending done event only while the error word is zero. While any error bit is set it changes nothing.
- R8: Command bit 5 (clear error) zeroes the error word and drops both pending events.
- R9: After a successful seeding run, one word per clock is pushed into the queue until it holds `DEPTH` words. Status bits 12:8 give the fill level. The pushed words follow the LFSR sequence: first 0x00000001, then next = (s >> 1) XOR (s[0] ? 0x80200003 : 0). No word is pushed before a seeding run succeeds or after one fails.
- R10: A read of offset 0x14 returns the oldest word and removes it. Reading an empty queue returns 0, leaves the level at 0 and sets error bit 4.
- R11: A seeding run may be issued again after a failed one. It runs the full `OP_CYCLES` again and, on success, starts the filling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Register access this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 8 | Byte offset of the register |
| req_wdata_i | input | 32 | Write data |
| rsp_rdata_o | output | 32 | Read data, valid in the same cycle as the read request |
| irq_o | output | 1 | Combined interrupt line for unmasked sources |
| force_fail_i | input | 1 | Test input that makes the operation being started fail |

## Verification
Read data is combinational, so each read shows the state left by the previous clock edge. A start accepted on edge E0 raises its done flag after edge E0+`OP_CYCLES`. With seeding, the first queue word lands one edge after that and the queue is full `DEPTH` edges later. The bench samples the status word exactly after edge `OP_CYCLES`-1 and again after edges `OP_CYCLES` and `OP_CYCLES`+1, so a done flag that is one cycle early or late is caught. Interrupt, error and underflow effects are checked on the read or line sample that directly follows the access that caused them.

// File: rtl/rng_ctrl_pkg.sv
package rng_ctrl_pkg;
  localparam logic [7:0] ADDR_CMD  = 8'h04;
  localparam logic [7:0] ADDR_CTRL = 8'h08;
  localparam logic [7:0] ADDR_STAT = 8'h0C;
  localparam logic [7:0] ADDR_ERR  = 8'h10;
  localparam logic [7:0] ADDR_FIFO = 8'h14;

  localparam int CMD_SELFTEST = 0;
  localparam int CMD_SEED     = 1;
  localparam int CMD_CLR_INT  = 4;
  localparam int CMD_CLR_ERR  = 5;

  localparam int CTRL_MASK_DONE = 5;
  localparam int CTRL_MASK_ERR  = 6;

  localparam int STAT_ST_DONE   = 4;
  localparam int STAT_SEED_DONE = 5;
  localparam int STAT_LVL_LSB   = 8;
  localparam int STAT_ERROR     = 16;

  localparam int ERR_ST_FAIL   = 2;
  localparam int ERR_STAT_FAIL = 3;
  localparam int ERR_UNDERFLOW = 4;

  typedef enum logic [1:0] {OP_NONE, OP_SELFTEST, OP_SEED} op_e;
endpackage

// File: rtl/rng_op_seq.sv
module rng_op_seq
  import rng_ctrl_pkg::*;
#(
  parameter int OP_CYCLES = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_st_i,
  input  logic start_seed_i,
  input  logic force_fail_i,
  output logic busy_o,
  output logic fin_o,
  output op_e  fin_op_o,
  output logic fin_fail_o
);
  localparam int CNT_W = $clog2(OP_CYCLES + 1);

  op_e              op_q;
  logic [CNT_W-1:0] cnt_q;
  logic             fail_q;

  assign busy_o     = (op_q != OP_NONE);
  assign fin_o      = busy_o && (cnt_q == '0);
  assign fin_op_o   = op_q;
  assign fin_fail_o = fail_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q   <= OP_NONE;
      cnt_q  <= '0;
      fail_q <= 1'b0;
    end else if (!busy_o) begin
      // self-test wins when both starts arrive together
      if (start_st_i || start_seed_i) begin
        op_q   <= start_st_i ? OP_SELFTEST : OP_SEED;
        cnt_q  <= CNT_W'(OP_CYCLES - 1);
        fail_q <= force_fail_i;
      end
    end else if (cnt_q == '0) begin
      op_q <= OP_NONE;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  p_busy_holds_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && cnt_q != '0 |=> busy_o && op_q == $past(op_q));

  p_start_ignored_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && cnt_q != '0 && (start_st_i || start_seed_i) |=> cnt_q == $past(cnt_q) - 1'b1);
endmodule

// File: rtl/rng_lfsr_src.sv
module rng_lfsr_src #(
  parameter int              W    = 32,
  parameter logic [W-1:0]    POLY = 32'h8020_0003,
  parameter logic [W-1:0]    INIT = 32'h0000_0001
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         advance_i,
  output logic [W-1:0] word_o
);
  logic [W-1:0] s_q;

  assign word_o = s_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        s_q <= INIT;
    else if (advance_i) s_q <= (s_q >> 1) ^ (s_q[0] ? POLY : '0);
  end

  p_lfsr_nonzero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_o != '0);
endmodule

// File: rtl/rng_out_fifo.sv
module rng_out_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 16
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         push_i,
  input  logic [W-1:0]                 data_i,
  input  logic                         pop_i,
  output logic [W-1:0]                 data_o,
  output logic [$clog2(DEPTH+1)-1:0]   level_o,
  output logic                         full_o,
  output logic                         empty_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LVL_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [LVL_W-1:0] cnt_q;
  logic             push_ok, pop_ok;

  assign full_o  = (cnt_q == LVL_W'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign push_ok = push_i && !full_o;
  assign pop_ok  = pop_i && !empty_o;
  assign level_o = cnt_q;
  assign data_o  = empty_o ? '0 : mem_q[rd_q];

  function automatic logic [PTR_W-1:0] inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_ok) wr_q <= inc(wr_q);
      if (pop_ok)  rd_q <= inc(rd_q);
      case ({push_ok, pop_ok})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  p_level_bound_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LVL_W'(DEPTH));

  p_empty_pop_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i && empty_o && !push_i |=> empty_o);
endmodule

// File: rtl/rng_ctrl_regs.sv
module rng_ctrl_regs
  import rng_ctrl_pkg::*;
#(
  parameter int OP_CYCLES = 64,
  parameter int DEPTH     = 16,
  parameter int DW        = 32,
  parameter int AW        = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  input  logic          req_write_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  output logic [DW-1:0] rsp_rdata_o,
  output logic          irq_o,
  input  logic          force_fail_i
);
  localparam int LVL_W = $clog2(DEPTH + 1);

  logic            wr_cmd, wr_ctrl, rd_en, rd_fifo;
  logic            start_st, start_seed, clr_int, clr_err;
  logic            busy, fin, fin_fail, seed_acc, st_acc, underflow;
  op_e             fin_op;
  logic [1:0]      mask_q;          // [0] done, [1] error
  logic            st_done_q, seed_done_q, seeded_q;
  logic            done_pend_q, err_pend_q;
  logic [DW-1:0]   err_q;
  logic [DW-1:0]   rng_word, fifo_word;
  logic [LVL_W-1:0] level;
  logic            full, empty, push;

  assign wr_cmd  = req_valid_i && req_write_i && (req_addr_i == ADDR_CMD);
  assign wr_ctrl = req_valid_i && req_write_i && (req_addr_i == ADDR_CTRL);
  assign rd_en   = req_valid_i && !req_write_i;
  assign rd_fifo = rd_en && (req_addr_i == ADDR_FIFO);

  assign start_st   = wr_cmd && req_wdata_i[CMD_SELFTEST];
  assign start_seed = wr_cmd && req_wdata_i[CMD_SEED];
  assign clr_int    = wr_cmd && req_wdata_i[CMD_CLR_INT];
  assign clr_err    = wr_cmd && req_wdata_i[CMD_CLR_ERR];
  assign st_acc     = start_st && !busy;
  assign seed_acc   = start_seed && !start_st && !busy;
  assign underflow  = rd_fifo && empty;
  assign push       = seeded_q && !full;

  rng_op_seq #(.OP_CYCLES(OP_CYCLES)) u_seq (
    .clk_i, .rst_ni,
    .start_st_i   (start_st),
    .start_seed_i (start_seed),
    .force_fail_i (force_fail_i),
    .busy_o       (busy),
    .fin_o        (fin),
    .fin_op_o     (fin_op),
    .fin_fail_o   (fin_fail)
  );

  rng_lfsr_src #(.W(DW)) u_lfsr (
    .clk_i, .rst_ni,
    .advance_i (push),
    .word_o    (rng_word)
  );

  rng_out_fifo #(.W(DW), .DEPTH(DEPTH)) u_fifo (
    .clk_i, .rst_ni,
    .push_i  (push),
    .data_i  (rng_word),
    .pop_i   (rd_fifo),
    .data_o  (fifo_word),
    .level_o (level),
    .full_o  (full),
    .empty_o (empty)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mask_q <= 2'b11;
    else if (wr_ctrl) mask_q <= {req_wdata_i[CTRL_MASK_ERR], req_wdata_i[CTRL_MASK_DONE]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_done_q   <= 1'b0;
      seed_done_q <= 1'b0;
      seeded_q    <= 1'b0;
    end else begin
      if (st_acc) st_done_q <= 1'b0;
      else if (fin && fin_op == OP_SELFTEST) st_done_q <= 1'b1;
      if (seed_acc) begin
        seed_done_q <= 1'b0;
        seeded_q    <= 1'b0;
      end else if (fin && fin_op == OP_SEED) begin
        seed_done_q <= 1'b1;
        if (!fin_fail) seeded_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q       <= '0;
      done_pend_q <= 1'b0;
      err_pend_q  <= 1'b0;
    end else begin
      logic [DW-1:0] err_n;
      logic          dp_n, ep_n;
      err_n = err_q;
      dp_n  = done_pend_q;
      ep_n  = err_pend_q;
      if (clr_err) begin
        err_n = '0;
        dp_n  = 1'b0;
        ep_n  = 1'b0;
      end else if (clr_int && err_q == '0) begin
        dp_n = 1'b0;
        ep_n = 1'b0;
      end
      if (fin) begin
        dp_n = 1'b1;
        if (fin_fail) begin
          ep_n = 1'b1;
          if (fin_op == OP_SEED) err_n[ERR_STAT_FAIL] = 1'b1;
          else                   err_n[ERR_ST_FAIL]   = 1'b1;
        end
      end
      if (underflow) begin
        ep_n = 1'b1;
        err_n[ERR_UNDERFLOW] = 1'b1;
      end
      err_q       <= err_n;
      done_pend_q <= dp_n;
      err_pend_q  <= ep_n;
    end
  end

  assign irq_o = (done_pend_q && !mask_q[0]) || (err_pend_q && !mask_q[1]);

  always_comb begin
    rsp_rdata_o = '0;
    if (rd_en) begin
      case (req_addr_i)
        ADDR_CTRL: begin
          rsp_rdata_o[CTRL_MASK_DONE] = mask_q[0];
          rsp_rdata_o[CTRL_MASK_ERR]  = mask_q[1];
        end
        ADDR_STAT: begin
          rsp_rdata_o[STAT_ST_DONE]   = st_done_q;
          rsp_rdata_o[STAT_SEED_DONE] = seed_done_q;
          rsp_rdata_o[STAT_LVL_LSB +: LVL_W] = level;
          rsp_rdata_o[STAT_ERROR]     = (err_q != '0);
        end
        ADDR_ERR:  rsp_rdata_o = err_q;
        ADDR_FIFO: rsp_rdata_o = fifo_word;
        default:   rsp_rdata_o = '0;
      endcase
    end
  end

  p_clr_int_blocked_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_int && !clr_err && err_q != '0 |=> err_q != '0 && err_pend_q);

  p_clr_err_wipes_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_err && !fin |=> err_q == '0 && !done_pend_q && !err_pend_q);

  p_fill_needs_seed_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seeded_q |=> level <= $past(level));

  p_fail_no_seed_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin && fin_fail |=> !seeded_q);
endmodule

// File: tb/rng_ctrl_regs_test.sv
module rng_ctrl_regs_test;
  localparam int N     = 64;
  localparam int DEPTH = 16;
  localparam logic [31:0] POLY = 32'h8020_0003;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_write_i = 1'b0;
  logic [7:0]  req_addr_i = '0;
  logic [31:0] req_wdata_i = '0;
  logic [31:0] rsp_rdata_o;
  logic        irq_o;
  logic        force_fail_i = 1'b0;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  rng_ctrl_regs #(.OP_CYCLES(N), .DEPTH(DEPTH)) uut (
    .clk_i, .rst_ni, .req_valid_i, .req_write_i, .req_addr_i,
    .req_wdata_i, .rsp_rdata_o, .irq_o, .force_fail_i
  );

  always #5 clk_i = ~clk_i;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic access(input bit w, input logic [7:0] a, input logic [31:0] d,
                        output logic [31:0] r);
    @(negedge clk_i);
    req_valid_i = 1'b1;
    req_write_i = w;
    req_addr_i  = a;
    req_wdata_i = d;
    #1 r = rsp_rdata_o;
    @(posedge clk_i);
    #1 req_valid_i = 1'b0;
    req_write_i = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    logic [31:0] r;
    access(1'b1, a, d, r);
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] r;
    access(1'b0, a, 32'h0, r);
    chk(req, r, exp);
  endtask

  task automatic irq_chk(input string req, input logic exp);
    @(negedge clk_i);
    chk(req, {31'h0, irq_o}, {31'h0, exp});
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  function automatic logic [31:0] stat(input bit st, input bit sd, input int lvl, input bit er);
    return (32'(st) << 4) | (32'(sd) << 5) | (32'(lvl) << 8) | (32'(er) << 16);
  endfunction

  function automatic logic [31:0] lfsr_next(input logic [31:0] s);
    return (s >> 1) ^ (s[0] ? POLY : 32'h0);
  endfunction

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] model;
    logic [31:0] r;
    idle(3);
    rst_ni = 1'b1;
    idle(2);

    // R1 reset state
    rd_chk("R1 ctrl reset", 8'h08, 32'h60);
    rd_chk("R1 status reset", 8'h0C, 32'h0);
    rd_chk("R1 error reset", 8'h10, 32'h0);
    irq_chk("R1 irq reset", 1'b0);
    // R2 command reads zero
    rd_chk("R2 cmd readback", 8'h04, 32'h0);

    // R10 underflow on empty queue
    rd_chk("R10 empty read", 8'h14, 32'h0);
    rd_chk("R10 underflow bit", 8'h10, 32'h10);
    rd_chk("R6 status error bit, level 0", 8'h0C, stat(0, 0, 0, 1));
    irq_chk("R5 error masked", 1'b0);
    wr(8'h08, 32'h20);
    irq_chk("R5 error unmasked", 1'b1);
    wr(8'h04, 32'h10);
    rd_chk("R7 clear-int blocked err", 8'h10, 32'h10);
    irq_chk("R7 clear-int blocked irq", 1'b1);
    wr(8'h04, 32'h20);
    rd_chk("R8 clear-err word", 8'h10, 32'h0);
    irq_chk("R8 clear-err irq", 1'b0);

    // R2 control keeps only mask bits
    wr(8'h08, 32'hFFFF_FFFF);
    rd_chk("R2 ctrl bits", 8'h08, 32'h60);
    wr(8'h08, 32'h0);
    rd_chk("R2 ctrl clear", 8'h08, 32'h0);

    // R3 self-test timing, R4 seed while busy ignored
    wr(8'h04, 32'h1);
    wr(8'h04, 32'h2);
    idle(N - 2);
    rd_chk("R3 self-test not yet done", 8'h0C, stat(0, 0, 0, 0));
    rd_chk("R3 self-test done at OP_CYCLES", 8'h0C, stat(1, 0, 0, 0));
    irq_chk("R5 done irq", 1'b1);
    idle(N + 4);
    rd_chk("R4 ignored seed", 8'h0C, stat(1, 0, 0, 0));
    wr(8'h04, 32'h10);
    irq_chk("R7 clear-int clears done", 1'b0);

    // R6 forced seed failure
    force_fail_i = 1'b1;
    wr(8'h04, 32'h2);
    force_fail_i = 1'b0;
    idle(N + 2);
    rd_chk("R6 seed fail error word", 8'h10, 32'h08);
    rd_chk("R9 no fill after failed seed", 8'h0C, stat(1, 1, 0, 1));
    irq_chk("R6 error irq", 1'b1);
    wr(8'h04, 32'h10);
    rd_chk("R7 clear-int keeps error", 8'h10, 32'h08);
    irq_chk("R7 clear-int keeps irq", 1'b1);
    wr(8'h04, 32'h20);
    rd_chk("R8 clear-err word", 8'h10, 32'h0);
    irq_chk("R8 clear-err drops both", 1'b0);

    // R6 forced self-test failure
    force_fail_i = 1'b1;
    wr(8'h04, 32'h1);
    force_fail_i = 1'b0;
    idle(N + 2);
    rd_chk("R6 self-test fail error word", 8'h10, 32'h04);
    wr(8'h04, 32'h20);
    irq_chk("R8 clear-err after self-test", 1'b0);

    // R11 reseed after failure, R5 done masked, R9 fill
    wr(8'h08, 32'h20);
    wr(8'h04, 32'h2);
    idle(N - 1);
    rd_chk("R11 reseed not yet done", 8'h0C, stat(1, 0, 0, 0));
    rd_chk("R11 reseed done", 8'h0C, stat(1, 1, 0, 0));
    rd_chk("R9 first push", 8'h0C, stat(1, 1, 1, 0));
    irq_chk("R5 done masked", 1'b0);
    wr(8'h08, 32'h0);
    irq_chk("R5 done unmasked", 1'b1);
    idle(20);
    rd_chk("R9 full level", 8'h0C, stat(1, 1, DEPTH, 0));

    // R10 pop order against LFSR model
    model = 32'h1;
    for (int i = 0; i < 24; i++) begin
      access(1'b0, 8'h14, 32'h0, r);
      chk($sformatf("R10 word %0d", i), r, model);
      model = lfsr_next(model);
    end
    idle(4);
    rd_chk("R9 refilled", 8'h0C, stat(1, 1, DEPTH, 0));
    rd_chk("R10 no underflow", 8'h10, 32'h0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule